// File: doc/BRIEF.md
# Remote read DMA port controller

This block streams bytes out of a local buffer memory toward a host that cannot address that memory itself. Software loads a starting buffer address and a byte count and pulses a start input. The controller then asks for the local bus, runs one fixed-shape memory read, places the fetched byte on its port data lines and pulses a port-write strobe so an external latch captures the byte. The host picks the byte out of the latch using its own address, from its DMA engine or its CPU, and answers with a read acknowledge. That acknowledge starts the fetch of the next byte.

Every memory read is a sequence of four bus-clock phases, t1 to t4. The phases start only after a bus grant, so another DMA channel can share the memory. A slow memory holds ready low to add whole wait cycles between t3 and t4. The first byte is fetched as soon as the block is started, so the latch already holds it before the host's first acknowledge. When the count is used up the block releases the bus and raises a done flag.

Top module: `rdma_port_ctrl`

## Requirements
- R1: After reset, bus_req, mem_rd, port_wr, busy and done are 0 and port_data is 0.
- R2: A start pulse with a nonzero xfer_len, accepted while the block is not busy, raises bus_req on the next clock. Phase t1 follows the first cycle in which bus_grant is sampled high. mem_rd is high from t2 to t4, so it first rises two cycles after the grant cycle.
- R3: mem_ready is sampled at the end of t3 and of each wait cycle. Each low sample adds one wait cycle. port_wr is therefore high in cycle g+4+w after bus_req rises, where g is the number of extra request cycles without a grant and w is the number of wait cycles.
- R4: port_wr is high for exactly one cycle per transfer, in t4. During that cycle port_data already shows the byte read, and it keeps that value until the next port_wr.
- R5: Transfer i reads buffer address base_addr+i, which wraps modulo 2^AW. mem_addr holds this address while mem_rd is high.
- R6: After every transfer except the last, the block keeps bus_req low and stays busy until an acknowledge arrives.
- R7: host_ack is synchronised and edge-detected. When a rising level is first sampled at clock edge k, bus_req rises after edge k+2. An acknowledge held high for many cycles causes only one refill.
- R8: An acknowledge edge that arrives during a memory cycle, or after the block has finished, has no effect.
- R9: The cycle after the last port_wr, done is 1, busy is 0 and bus_req is 0. done stays 1 until the next accepted start.
- R10: A start with xfer_len equal to 0 raises done on the next clock and runs no memory cycle.
- R11: A start pulse while busy is ignored. The address sequence and the number of transfers are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted when not busy |
| base_addr | input | AW | First buffer address |
| xfer_len | input | CW | Number of bytes to move |
| bus_req | output | 1 | Local bus request, high from request through t4 |
| bus_grant | input | 1 | Local bus grant |
| mem_addr | output | AW | Buffer address of the current transfer |
| mem_rd | output | 1 | Memory read strobe, t2 to t4 |
| mem_rdata | input | DW | Data returned by the memory |
| mem_ready | input | 1 | Memory ready, low inserts wait cycles |
| port_wr | output | 1 | Strobe that loads the external latch |
| port_data | output | DW | Byte presented to the external latch |
| host_ack | input | 1 | Host read acknowledge, asynchronous |
| busy | output | 1 | A transfer sequence is in progress |
| done | output | 1 | The sequence has finished |

## Verification
Every result has a fixed delay, so the bench predicts the cycle of each one and samples on the falling edge of that cycle. bus_req rises one cycle after start. mem_rd rises g+2 cycles later. port_wr appears in cycle g+4+w, and done follows one cycle after the last strobe. After an acknowledge, bus_req stays low at the first two falling edges and is high at the third. The bench sweeps grant delay, wait count and length over 0 to 2, 0 to 2 and 1 to 3, with start addresses that include a wrap. It also counts exact cycles to show that acknowledges during a memory cycle, held acknowledges and restarts while busy add no transfer.

// File: rtl/rdma_port_ctrl.sv
module rdma_port_ctrl #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [CW-1:0] xfer_len,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic          port_wr,
  output logic [DW-1:0] port_data,
  input  logic          host_ack,
  output logic          busy,
  output logic          done
);

  typedef enum logic [3:0] {
    S_IDLE, S_REQ, S_T1, S_T2, S_T3, S_TW, S_T4, S_HOLD, S_DONE
  } st_t;

  st_t           st;
  logic [AW-1:0] addr;
  logic [CW-1:0] left;
  logic [2:0]    ack_sy;
  logic          ack_edge;

  always_ff @(posedge clk) begin
    if (!rst_n) ack_sy <= '0;
    else        ack_sy <= {ack_sy[1:0], host_ack};
  end

  assign ack_edge = ack_sy[1] & ~ack_sy[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      addr      <= '0;
      left      <= '0;
      port_data <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE:
          if (start) begin
            addr <= base_addr;
            left <= xfer_len;
            st   <= (xfer_len == '0) ? S_DONE : S_REQ;
          end
        S_REQ:  if (bus_grant) st <= S_T1;
        S_T1:   st <= S_T2;
        S_T2:   st <= S_T3;
        S_T3, S_TW:
          if (mem_ready) begin
            port_data <= mem_rdata;
            st        <= S_T4;
          end else begin
            st <= S_TW;
          end
        S_T4: begin
          addr <= addr + 1'b1;
          left <= left - 1'b1;
          st   <= (left == CW'(1)) ? S_DONE : S_HOLD;
        end
        S_HOLD: if (ack_edge) st <= S_REQ;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_addr = addr;
  assign bus_req  = (st == S_REQ) || (st == S_T1) || (st == S_T2) ||
                    (st == S_T3)  || (st == S_TW) || (st == S_T4);
  assign mem_rd   = (st == S_T2) || (st == S_T3) || (st == S_TW) || (st == S_T4);
  assign port_wr  = (st == S_T4);
  assign busy     = (st != S_IDLE) && (st != S_DONE);
  assign done     = (st == S_DONE);

  AST_GRANT_GATES_T1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_REQ && !bus_grant) |=> (st == S_REQ && !mem_rd)); // R2
  AST_READY_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_T3 || st == S_TW) && !mem_ready) |=> (mem_rd && !port_wr)); // R3
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr |=> !port_wr); // R4
  AST_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD) |=> $stable(port_data)); // R4
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr |=> (mem_addr == AW'($past(mem_addr) + 1'b1))); // R5
  AST_HOLD_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && !ack_edge) |=> !bus_req); // R6
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!bus_req && !busy)); // R9

endmodule

// File: tb/rdma_port_ctrl_bench.sv
`timescale 1ns/1ps
module rdma_port_ctrl_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [15:0] base_addr = '0;
  logic [15:0] xfer_len = '0;
  logic        bus_req, bus_grant = 0;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_rdata;
  logic        mem_ready = 0;
  logic        port_wr;
  logic [7:0]  port_data;
  logic        host_ack = 0;
  logic        busy, done;

  int total = 0, bad = 0;
  int gcfg = 0, wcfg = 0, gw = 0, rw = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rdma_port_ctrl u_rdma_port_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .xfer_len(xfer_len), .bus_req(bus_req), .bus_grant(bus_grant),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .port_wr(port_wr), .port_data(port_data),
    .host_ack(host_ack), .busy(busy), .done(done)
  );

  function automatic logic [7:0] fmem(input logic [15:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'h5C;
  endfunction

  assign mem_rdata = fmem(mem_addr);

  always @(negedge clk) begin
    if (!bus_req) begin
      gw = 0; bus_grant = 0;
    end else if (!bus_grant) begin
      if (gw == gcfg) bus_grant = 1; else gw++;
    end
    if (!mem_rd) begin
      rw = 0; mem_ready = 0;
    end else begin
      rw++; mem_ready = (rw >= 2 + wcfg);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] a, input int n, input int g, input int w);
    gcfg = g; wcfg = w;
    base_addr = a; xfer_len = 16'(n); start = 1;
    @(negedge clk); start = 0;
    chk(bus_req, "R2 request after start", int'(bus_req), 1);
    chk(!done, "R9 done cleared by start", int'(done), 0);
    for (int i = 0; i < n; i++) begin
      int  c = 0;
      bit  seen = 0;
      logic [15:0] ea = a + 16'(i);
      bit  lng = (i % 2 == 1);
      while (!port_wr && c < 40) begin
        if (mem_rd && !seen) begin
          seen = 1;
          chk(c == g + 2, "R2 mem_rd after grant", c, g + 2);
          chk(mem_addr == ea, "R5 address", int'(mem_addr), int'(ea));
        end
        if (i == 0 && n > 1 && c == 1) host_ack = 1;
        if (i == 0 && n > 1 && c == 2) host_ack = 0;
        @(negedge clk); c++;
      end
      chk(c == g + 4 + w, "R3 strobe cycle", c, g + 4 + w);
      chk(port_data == fmem(ea), "R4 data at strobe", int'(port_data), int'(fmem(ea)));
      @(negedge clk);
      chk(!port_wr, "R4 strobe one cycle", int'(port_wr), 0);
      if (i < n - 1) begin
        for (int h = 0; h < 3; h++) begin
          chk(!bus_req && busy && !done, "R6 R8 waiting for ack", int'(bus_req), 0);
          chk(port_data == fmem(ea), "R4 data held", int'(port_data), int'(fmem(ea)));
          @(negedge clk);
        end
        if (i == 0) begin
          base_addr = a + 16'h0100; xfer_len = 16'd7; start = 1;
          @(negedge clk); start = 0;
          chk(!bus_req && busy, "R11 start while busy", int'(bus_req), 0);
        end
        host_ack = 0;
        @(negedge clk);
        chk(!bus_req, "R7 level ack no refill", int'(bus_req), 0);
        host_ack = 1;
        for (int k = 1; k <= 3; k++) begin
          @(negedge clk);
          if (k == 1 && !lng) host_ack = 0;
          if (k < 3) chk(!bus_req, "R7 ack latency early", int'(bus_req), 0);
          else       chk(bus_req, "R7 ack latency", int'(bus_req), 1);
        end
      end else begin
        chk(done && !busy && !bus_req, "R9 done after last", int'(done), 1);
      end
    end
    host_ack = 0;
    @(negedge clk);
    host_ack = 1;
    @(negedge clk); @(negedge clk);
    host_ack = 0;
    repeat (3) @(negedge clk);
    chk(!bus_req && done, "R8 ack after done", int'(bus_req), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!bus_req && !mem_rd && !port_wr && !busy && !done && port_data == 8'h00,
        "R1 reset state", int'(busy), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done, "R1 idle after reset", int'(done), 0);
    for (int g = 0; g < 3; g++)
      for (int w = 0; w < 3; w++)
        for (int n = 1; n <= 3; n++) begin
          logic [15:0] a;
          case ((g + w + n) % 3)
            0: a = 16'hFFFE;
            1: a = 16'h0010;
            default: a = 16'h1234;
          endcase
          run(a, n, g, w);
        end
    base_addr = 16'h0040; xfer_len = 16'd0; start = 1;
    @(negedge clk); start = 0;
    chk(done && !bus_req && !busy, "R10 zero length", int'(done), 1);
    repeat (4) begin
      chk(!bus_req && !mem_rd, "R10 no memory cycle", int'(mem_rd), 0);
      @(negedge clk);
    end
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog requirement=all actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule